// File: doc/BRIEF.md
# Single-Bit Manipulation Unit

This unit carries out one single-bit instruction per accepted request on a byte-wide operand. The caller supplies an operation code, a bit number, the operand byte and the current carry and zero flags. The unit returns the updated byte, a write-back request and the resulting carry and zero flags. Computing the operand's address and sequencing the memory read and write belong to the surrounding datapath.

The operations fall into two groups. Modifying operations (set, clear, invert, store carry and inverted store carry) change only the selected bit and ask for a write-back. Read-only operations (test, load to carry, inverted load and the six carry-logic forms) leave the byte as it was and never ask for a write-back. Results appear one clock after the request, with the write-back request pulsing in the same cycle as the output strobe.

Top module: `bitop_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, `out_valid` and `out_wb` are 0; a request presented during reset produces no output strobe.
- R2: A request with `in_valid` high yields `out_valid` high exactly one clock later for one cycle per request; `out_wb` is never high without `out_valid`, and back-to-back requests give back-to-back results.
- R3: The bit selector uses only the low 3 bits of `in_bitnum`, so the mask is 1 shifted left by (`in_bitnum` mod 8); for example bit number 12 selects bit 4 and 15 selects bit 7.
- R4: Code 0 sets, code 1 clears and code 2 inverts the selected bit; all three drive `out_wb` = 1 and pass carry and zero through unchanged.
- R5: Code 3 (test) gives `out_zero` = 1 when the selected bit is 0 and 0 when it is 1, leaves carry unchanged, returns the operand unchanged and drives `out_wb` = 0.
- R6: Code 4 copies the selected bit into carry; code 5 copies its complement; both leave zero unchanged.
- R7: Code 6 writes the incoming carry into the selected bit and code 7 writes its complement; other bits are kept, `out_wb` = 1 and both flags pass through.
- R8: Code 8 sets carry to (bit AND carry), code 10 to (bit OR carry), code 12 to (bit XOR carry).
- R9: Codes 9, 11 and 13 do the same as 8, 10 and 12 but with the complement of the selected bit.
- R10: Every read-only operation (codes 3, 4, 5 and 8 to 13) returns the operand byte unchanged with `out_wb` = 0; all except test leave zero unchanged.
- R11: Codes 14 and 15 are no-ops: operand returned unchanged, `out_wb` = 0, carry and zero passed through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 4 | Operation code |
| in_bitnum | input | SEL_W (4) | Bit number; only the low 3 bits are used |
| in_operand | input | DATA_W (8) | Operand byte |
| in_carry | input | 1 | Current carry flag |
| in_zero | input | 1 | Current zero flag |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_data | output | DATA_W (8) | Resulting byte |
| out_wb | output | 1 | Write-back request for `out_data` |
| out_carry | output | 1 | Resulting carry flag |
| out_zero | output | 1 | Resulting zero flag |

## Verification
The bench aims at the polarity pairs: each inverted form of load, store and carry-logic is run with the bit both set and clear, so a design that drops an inversion or swaps a pair returns the wrong carry or wrong stored bit. Bit numbers 8, 12 and 15 check the wrap, which a design that uses the full selector would turn into an empty mask and leave the byte unchanged. Test is run against zero flags of both starting values, catching a design that inverts the sense of Z or lets test disturb carry, and the store cases use operands of all ones and all zeros so that a store that only sets or only clears is caught. Reserved codes, back-to-back requests and a reset that lands on a live request catch a spurious write-back or a stretched strobe.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      BOP_SET  = 4'd0,
      BOP_CLR  = 4'd1,
      BOP_INV  = 4'd2,
      BOP_TST  = 4'd3,
      BOP_LD   = 4'd4,
      BOP_ILD  = 4'd5,
      BOP_ST   = 4'd6,
      BOP_IST  = 4'd7,
      BOP_AND  = 4'd8,
      BOP_IAND = 4'd9,
      BOP_OR   = 4'd10,
      BOP_IOR  = 4'd11,
      BOP_XOR  = 4'd12,
      BOP_IXOR = 4'd13,
      BOP_RSV0 = 4'd14,
      BOP_RSV1 = 4'd15
   } bop_e;

   function automatic logic bop_writes(input bop_e op);
      return (op == BOP_SET) || (op == BOP_CLR) || (op == BOP_INV) ||
             (op == BOP_ST)  || (op == BOP_IST);
   endfunction

endpackage

// File: rtl/bitop_mask.sv
module bitop_mask #(
   parameter int DATA_W = 8,
   parameter int SEL_W  = 4,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic [SEL_W-1:0]  sel,
   input  logic [DATA_W-1:0] operand,
   output logic [DATA_W-1:0] mask,
   output logic              bit_val
);

   if ((DATA_W & (DATA_W - 1)) != 0 || DATA_W < 2) begin : g_bad_width
      $error("bitop_mask: DATA_W must be a power of two of at least 2");
   end
   if (SEL_W < IDX_W) begin : g_bad_sel
      $error("bitop_mask: SEL_W too narrow for DATA_W");
   end

   logic [IDX_W-1:0] idx;
   assign idx = IDX_W'(sel);   // upper selector bits wrap (R3)

   for (genvar i = 0; i < DATA_W; i++) begin : g_dec
      assign mask[i] = (idx == IDX_W'(i));
   end

   assign bit_val = |(operand & mask);

   always_comb begin
      assert_mask_onehot_R3: assert ($onehot(mask));
   end

endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
   import bitop_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [OP_W-1:0]   op,
   input  logic [DATA_W-1:0] operand,
   input  logic [DATA_W-1:0] mask,
   input  logic              bit_val,
   input  logic              c_in,
   input  logic              z_in,
   output logic [DATA_W-1:0] data,
   output logic              wb,
   output logic              c_out,
   output logic              z_out
);

   bop_e code;
   assign code = bop_e'(op);

   always_comb begin
      data  = operand;
      c_out = c_in;
      z_out = z_in;
      wb    = bop_writes(code);
      case (code)
         BOP_SET:  data  = operand | mask;
         BOP_CLR:  data  = operand & ~mask;
         BOP_INV:  data  = operand ^ mask;
         BOP_TST:  z_out = ~bit_val;
         BOP_LD:   c_out = bit_val;
         BOP_ILD:  c_out = ~bit_val;
         BOP_ST:   data  = (operand & ~mask) | (c_in ? mask : '0);
         BOP_IST:  data  = (operand & ~mask) | (c_in ? '0 : mask);
         BOP_AND:  c_out = bit_val & c_in;
         BOP_IAND: c_out = ~bit_val & c_in;
         BOP_OR:   c_out = bit_val | c_in;
         BOP_IOR:  c_out = ~bit_val | c_in;
         BOP_XOR:  c_out = bit_val ^ c_in;
         BOP_IXOR: c_out = ~bit_val ^ c_in;
         default:  ;
      endcase
   end

   always_comb begin
      // only the selected bit may differ from the operand (R4, R7)
      assert_only_sel_bit_R4: assert (((data ^ operand) & ~mask) == '0);
      // no write-back means the byte is untouched (R10)
      assert_ro_unchanged_R10: assert (wb || (data == operand));
   end

endmodule

// File: rtl/bitop_stage.sv
module bitop_stage #(
   parameter int DATA_W    = 8,
   parameter bit REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld_in,
   input  logic [DATA_W-1:0] data_in,
   input  logic              wb_in,
   input  logic              c_in,
   input  logic              z_in,
   output logic              vld_out,
   output logic [DATA_W-1:0] data_out,
   output logic              wb_out,
   output logic              c_out,
   output logic              z_out
);

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_out  <= 1'b0;
            wb_out   <= 1'b0;
            data_out <= '0;
            c_out    <= 1'b0;
            z_out    <= 1'b0;
         end else begin
            vld_out  <= vld_in;
            wb_out   <= vld_in & wb_in;
            data_out <= data_in;
            c_out    <= c_in;
            z_out    <= z_in;
         end
      end

      assert_wb_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
         wb_out |-> vld_out);
   end else begin : g_comb
      assign vld_out  = vld_in;
      assign wb_out   = vld_in & wb_in;
      assign data_out = data_in;
      assign c_out    = c_in;
      assign z_out    = z_in;
   end

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
   import bitop_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int SEL_W   = 4,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [OP_W-1:0]   in_op,
   input  logic [SEL_W-1:0]  in_bitnum,
   input  logic [DATA_W-1:0] in_operand,
   input  logic              in_carry,
   input  logic              in_zero,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_wb,
   output logic              out_carry,
   output logic              out_zero
);

   logic [DATA_W-1:0] mask;
   logic              bit_val;
   logic [DATA_W-1:0] alu_data;
   logic              alu_wb, alu_c, alu_z;

   bitop_mask #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_mask (
      .sel     (in_bitnum),
      .operand (in_operand),
      .mask    (mask),
      .bit_val (bit_val)
   );

   bitop_alu #(.DATA_W(DATA_W)) u_alu (
      .op      (in_op),
      .operand (in_operand),
      .mask    (mask),
      .bit_val (bit_val),
      .c_in    (in_carry),
      .z_in    (in_zero),
      .data    (alu_data),
      .wb      (alu_wb),
      .c_out   (alu_c),
      .z_out   (alu_z)
   );

   bitop_stage #(.DATA_W(DATA_W), .REGISTERED(REG_OUT)) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .vld_in   (in_valid),
      .data_in  (alu_data),
      .wb_in    (alu_wb),
      .c_in     (alu_c),
      .z_in     (alu_z),
      .vld_out  (out_valid),
      .data_out (out_data),
      .wb_out   (out_wb),
      .c_out    (out_carry),
      .z_out    (out_zero)
   );

   if (REG_OUT) begin : g_chk
      logic ro_op, rsv_op;
      assign ro_op  = (in_op == BOP_TST) || (in_op == BOP_LD) || (in_op == BOP_ILD) ||
                      (in_op >= BOP_AND && in_op <= BOP_IXOR);
      assign rsv_op = (in_op >= BOP_RSV0);

      assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      assert_valid_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
      assert_test_keeps_c_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_op == BOP_TST) |=> (out_carry == $past(in_carry)));
      assert_readonly_no_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && ro_op) |=> (!out_wb && out_data == $past(in_operand)));
      assert_reserved_noop_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && rsv_op) |=> (!out_wb && out_carry == $past(in_carry) &&
                                   out_zero == $past(in_zero)));
      assert_modify_wb_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && bop_writes(bop_e'(in_op))) |=> out_wb);
   end

endmodule

// File: tb/bitop_unit_bench.sv
`timescale 1ns/1ps
module bitop_unit_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [3:0] in_op = '0;
   logic [3:0] in_bitnum = '0;
   logic [7:0] in_operand = '0;
   logic       in_carry = 1'b0;
   logic       in_zero = 1'b0;
   logic       out_valid, out_wb, out_carry, out_zero;
   logic [7:0] out_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   bitop_unit u_bitop_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_bitnum(in_bitnum), .in_operand(in_operand), .in_carry(in_carry),
      .in_zero(in_zero), .out_valid(out_valid), .out_data(out_data),
      .out_wb(out_wb), .out_carry(out_carry), .out_zero(out_zero)
   );

   // op, bitnum, operand, c, z | data, wb, c, z
   localparam int NV = 31;
   localparam logic [28:0] VEC [NV] = '{
      {4'd0, 4'd3,  8'h00, 1'b0, 1'b0, 8'h08, 1'b1, 1'b0, 1'b0},
      {4'd0, 4'd7,  8'h7F, 1'b1, 1'b1, 8'hFF, 1'b1, 1'b1, 1'b1},
      {4'd1, 4'd0,  8'hFF, 1'b0, 1'b0, 8'hFE, 1'b1, 1'b0, 1'b0},
      {4'd1, 4'd12, 8'hFF, 1'b1, 1'b0, 8'hEF, 1'b1, 1'b1, 1'b0},
      {4'd2, 4'd5,  8'hA5, 1'b0, 1'b1, 8'h85, 1'b1, 1'b0, 1'b1},
      {4'd2, 4'd1,  8'hA5, 1'b1, 1'b0, 8'hA7, 1'b1, 1'b1, 1'b0},
      {4'd3, 4'd2,  8'h04, 1'b1, 1'b1, 8'h04, 1'b0, 1'b1, 1'b0},
      {4'd3, 4'd6,  8'h04, 1'b0, 1'b0, 8'h04, 1'b0, 1'b0, 1'b1},
      {4'd4, 4'd7,  8'h80, 1'b0, 1'b0, 8'h80, 1'b0, 1'b1, 1'b0},
      {4'd4, 4'd0,  8'hFE, 1'b1, 1'b1, 8'hFE, 1'b0, 1'b0, 1'b1},
      {4'd5, 4'd0,  8'hFE, 1'b0, 1'b0, 8'hFE, 1'b0, 1'b1, 1'b0},
      {4'd5, 4'd3,  8'h08, 1'b1, 1'b0, 8'h08, 1'b0, 1'b0, 1'b0},
      {4'd6, 4'd4,  8'h00, 1'b1, 1'b0, 8'h10, 1'b1, 1'b1, 1'b0},
      {4'd6, 4'd4,  8'hFF, 1'b0, 1'b1, 8'hEF, 1'b1, 1'b0, 1'b1},
      {4'd7, 4'd2,  8'hFF, 1'b1, 1'b0, 8'hFB, 1'b1, 1'b1, 1'b0},
      {4'd7, 4'd2,  8'h00, 1'b0, 1'b0, 8'h04, 1'b1, 1'b0, 1'b0},
      {4'd8, 4'd1,  8'h02, 1'b1, 1'b0, 8'h02, 1'b0, 1'b1, 1'b0},
      {4'd8, 4'd1,  8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
      {4'd9, 4'd1,  8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0},
      {4'd9, 4'd1,  8'h02, 1'b1, 1'b0, 8'h02, 1'b0, 1'b0, 1'b0},
      {4'd10,4'd6,  8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
      {4'd10,4'd6,  8'h40, 1'b0, 1'b1, 8'h40, 1'b0, 1'b1, 1'b1},
      {4'd11,4'd6,  8'h40, 1'b0, 1'b0, 8'h40, 1'b0, 1'b0, 1'b0},
      {4'd11,4'd6,  8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0},
      {4'd12,4'd0,  8'h01, 1'b1, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0},
      {4'd12,4'd0,  8'h01, 1'b0, 1'b0, 8'h01, 1'b0, 1'b1, 1'b0},
      {4'd13,4'd0,  8'h01, 1'b1, 1'b0, 8'h01, 1'b0, 1'b1, 1'b0},
      {4'd13,4'd0,  8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
      {4'd14,4'd3,  8'h55, 1'b1, 1'b1, 8'h55, 1'b0, 1'b1, 1'b1},
      {4'd15,4'd8,  8'hAA, 1'b0, 1'b0, 8'hAA, 1'b0, 1'b0, 1'b0},
      {4'd0, 4'd15, 8'h00, 1'b0, 1'b0, 8'h80, 1'b1, 1'b0, 1'b0}
   };

   function automatic string req_of(input logic [3:0] op);
      case (op)
         4'd0, 4'd1, 4'd2:    return "R4";
         4'd3:                return "R5";
         4'd4, 4'd5:          return "R6";
         4'd6, 4'd7:          return "R7";
         4'd8, 4'd10, 4'd12:  return "R8";
         4'd9, 4'd11, 4'd13:  return "R9";
         default:             return "R11";
      endcase
   endfunction

   task automatic check_out(input string req, input logic ev, input logic [7:0] ed,
                            input logic ewb, input logic ec, input logic ez);
      checks++;
      if (out_valid !== ev || out_wb !== ewb ||
          (ev && (out_data !== ed || out_carry !== ec || out_zero !== ez))) begin
         errors++;
         $display("FAIL %s: got v=%b d=%h wb=%b c=%b z=%b, expected v=%b d=%h wb=%b c=%b z=%b",
                  req, out_valid, out_data, out_wb, out_carry, out_zero,
                  ev, ed, ewb, ec, ez);
      end
   endtask

   task automatic drive(input logic [3:0] op, input logic [3:0] bn, input logic [7:0] d,
                        input logic c, input logic z);
      in_valid = 1'b1; in_op = op; in_bitnum = bn; in_operand = d;
      in_carry = c; in_zero = z;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got hang, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check_out("R1 reset", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check_out("R1 after reset", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);

      // table walk, back-to-back requests (R2)
      for (int i = 0; i < NV; i++) begin
         logic [28:0] v;
         v = VEC[i];
         drive(v[28:25], v[24:21], v[20:13], v[12], v[11]);
         @(negedge clk);
         check_out(req_of(v[28:25]), 1'b1, v[10:3], v[2], v[1], v[0]);
      end
      in_valid = 1'b0;
      @(negedge clk);
      check_out("R2 strobe ends", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);

      // R3 wrap: bit number 9 selects bit 1
      drive(4'd2, 4'd9, 8'h00, 1'b0, 1'b0);
      @(negedge clk);
      check_out("R3 wrap 9", 1'b1, 8'h02, 1'b1, 1'b0, 1'b0);
      // R10 test on wrapped bit keeps byte, no write-back
      drive(4'd3, 4'd13, 8'hDF, 1'b1, 1'b0);
      @(negedge clk);
      check_out("R10 test ro", 1'b1, 8'hDF, 1'b0, 1'b1, 1'b1);
      // R10 load leaves zero flag as it was
      drive(4'd4, 4'd2, 8'h04, 1'b0, 1'b1);
      @(negedge clk);
      check_out("R10 load keeps z", 1'b1, 8'h04, 1'b0, 1'b1, 1'b1);
      in_valid = 1'b0;
      @(negedge clk);
      check_out("R2 idle", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);

      // R1 reset landing on a live request
      drive(4'd0, 4'd0, 8'h00, 1'b0, 1'b0);
      rst_n = 1'b0;
      @(negedge clk);
      check_out("R1 reset on request", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
      in_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check_out("R1 post reset idle", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule